// File: doc/BRIEF.md
# Register-File ALU with Shift Unit

This block is the data-processing half of a small accumulator-free processor core. Each cycle it may accept one instruction word. From that word it picks a destination register, which is also the first operand, and a second operand: either another register of the file or an immediate constant held in the low bits of the word. It then runs a bitwise, arithmetic, compare, test or shift/rotate operation. The result goes back into the destination register unless the operation only sets flags. The zero and carry flags are kept in registers of their own.

The core that owns this block sequences the program, fetches the words and decides when to present them. The ALU acts only in cycles where both the clock enable and the instruction-valid strobe are high. Running the enable at a fraction of the clock lets the block sit in a fast clock domain without extra timing margin. A registered read port lets the surrounding logic, or a bench, see any register one cycle after it selects it. The data width and the register-address width are parameters, with defaults of 8 bits and 16 registers. The instruction word is 6 + REG_AW + DATA_W bits wide, which is 18 bits with the defaults.

Top module: `rf_alu_core`

## Requirements
- R1: Instruction fields (default widths): bits [17:13] are the opcode; bit 12 set selects register sY (address in bits [7:4]) as the second operand, and bit 12 clear selects the constant in bits [7:0]; bits [11:8] address the destination sX. The destination may equal sY.
- R2: Opcode 00000 (copy) writes the second operand into sX and leaves both flags unchanged.
- R3: Opcodes 00101, 00110 and 00111 write sX AND, OR and XOR the operand into sX, clear C, and set Z exactly when the result is zero.
- R4: Opcode 01100 writes sX plus the operand, and opcode 01101 adds the C flag in as well. C takes the carry out of the most significant bit, and Z is set when the written value is zero.
- R5: Opcode 01110 writes sX minus the operand, and opcode 01111 also subtracts the C flag. C takes the borrow, and Z is set when the written value is zero.
- R6: Opcode 01001 (test) never writes sX. It sets Z when sX AND the operand is zero, and sets C to the odd parity (XOR of all bits) of that AND.
- R7: Opcode 01011 is not used. Opcode 01010 (compare) never writes sX, and sets C and Z exactly as the subtraction of R5 would.
- R8: Opcode 10000 is the shift group, selected by bits [3:0]. Left shifts, with the new LSB in brackets: 0000 (old C), 0010 (old MSB, a rotate), 0100 (old LSB), 0110 (0), 0111 (1). Right shifts, with the new MSB in brackets: 1000 (old C), 1010 (old MSB), 1100 (old LSB, a rotate), 1110 (0), 1111 (1). C takes the bit shifted out, and Z is set when the result is zero.
- R9: Any other opcode, and any other shift-group code in bits [3:0], changes neither the register file nor the flags.
- R10: When the clock enable or the valid strobe is low, neither the register file nor the flags change.
- R11: Synchronous active-high reset clears Z, C and the read port output. Register contents survive a reset.
- R12: The read port returns the register addressed by rd_addr one clock after the address is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Clock enable; the ALU acts only while high |
| instr_valid | input | 1 | Instruction word is valid this cycle |
| instr | input | 6+REG_AW+DATA_W | Instruction word (opcode, operand select, sX, constant/sY, shift code) |
| rd_addr | input | REG_AW | Register address for the read port |
| rd_data | output | DATA_W | Registered contents of the addressed register |
| flag_z | output | 1 | Zero flag |
| flag_c | output | 1 | Carry/borrow flag |

## Verification
The assertions assume that the flags and the register file change only in cycles where both en and instr_valid were high at the clock edge. They also assume that an opcode word in a flag-only or undefined slot never produces a write strobe. The stimulus holds instr_valid and en steady across each rising edge, drives every opcode value the requirements name, and drives undefined opcodes and shift codes only to check that nothing changes. The sweeps cover operand pairs that include zero, all-ones and the carry-out boundary. Every carry-in case starts from a known flag value, which a shift of a preloaded scratch register sets up.

// File: rtl/rfalu_pkg.sv
package rfalu_pkg;

  localparam int OPC_W = 5;
  localparam int SHC_W = 4;

  typedef enum logic [OPC_W-1:0] {
    OP_LOAD  = 5'b00000,
    OP_AND   = 5'b00101,
    OP_OR    = 5'b00110,
    OP_XOR   = 5'b00111,
    OP_TEST  = 5'b01001,
    OP_CMP   = 5'b01010,
    OP_ADD   = 5'b01100,
    OP_ADDC  = 5'b01101,
    OP_SUB   = 5'b01110,
    OP_SUBC  = 5'b01111,
    OP_SHIFT = 5'b10000
  } opcode_e;

  // shift-group sub-codes in the low instruction bits
  localparam logic [SHC_W-1:0] SH_L_CARRY = 4'b0000;
  localparam logic [SHC_W-1:0] SH_L_ROT   = 4'b0010;
  localparam logic [SHC_W-1:0] SH_L_KEEP  = 4'b0100;
  localparam logic [SHC_W-1:0] SH_L_ZERO  = 4'b0110;
  localparam logic [SHC_W-1:0] SH_L_ONE   = 4'b0111;
  localparam logic [SHC_W-1:0] SH_R_CARRY = 4'b1000;
  localparam logic [SHC_W-1:0] SH_R_KEEP  = 4'b1010;
  localparam logic [SHC_W-1:0] SH_R_ROT   = 4'b1100;
  localparam logic [SHC_W-1:0] SH_R_ZERO  = 4'b1110;
  localparam logic [SHC_W-1:0] SH_R_ONE   = 4'b1111;

  typedef enum logic [2:0] {
    CL_NONE,
    CL_MOVE,
    CL_BITWISE,
    CL_PARITY,
    CL_ADDER,
    CL_SUBTR,
    CL_SHIFT
  } class_e;

  typedef enum logic [1:0] {
    BW_AND,
    BW_OR,
    BW_XOR
  } bitop_e;

  typedef struct packed {
    class_e cls;
    bitop_e bitop;
    logic   with_carry;
    logic   writes;
    logic   flags;
  } ctl_t;

endpackage

// File: rtl/rfalu_decode.sv
module rfalu_decode
  import rfalu_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int REG_AW = 4,
  localparam int INSTR_W = OPC_W + 1 + REG_AW + DATA_W
) (
  input  logic [INSTR_W-1:0] instr,
  output ctl_t               ctl,
  output logic               sel_reg,
  output logic [REG_AW-1:0]  x_addr,
  output logic [REG_AW-1:0]  y_addr,
  output logic [DATA_W-1:0]  imm
);

  localparam int SEL_BIT = INSTR_W - OPC_W - 1;

  logic [OPC_W-1:0] op_bits;

  assign op_bits = instr[INSTR_W-1 -: OPC_W];
  assign sel_reg = instr[SEL_BIT];
  assign x_addr  = instr[DATA_W +: REG_AW];
  assign y_addr  = instr[DATA_W-1 -: REG_AW];
  assign imm     = instr[DATA_W-1:0];

  always_comb begin
    ctl            = '0;
    ctl.cls        = CL_NONE;
    ctl.bitop      = BW_AND;
    case (op_bits)
      OP_LOAD: begin
        ctl.cls    = CL_MOVE;
        ctl.writes = 1'b1;
      end
      OP_AND, OP_OR, OP_XOR: begin
        ctl.cls    = CL_BITWISE;
        ctl.writes = 1'b1;
        ctl.flags  = 1'b1;
        ctl.bitop  = (op_bits == OP_AND) ? BW_AND :
                     (op_bits == OP_OR)  ? BW_OR  : BW_XOR;
      end
      OP_TEST: begin
        ctl.cls   = CL_PARITY;
        ctl.flags = 1'b1;
      end
      OP_CMP: begin
        ctl.cls   = CL_SUBTR;
        ctl.flags = 1'b1;
      end
      OP_ADD, OP_ADDC: begin
        ctl.cls        = CL_ADDER;
        ctl.writes     = 1'b1;
        ctl.flags      = 1'b1;
        ctl.with_carry = (op_bits == OP_ADDC);
      end
      OP_SUB, OP_SUBC: begin
        ctl.cls        = CL_SUBTR;
        ctl.writes     = 1'b1;
        ctl.flags      = 1'b1;
        ctl.with_carry = (op_bits == OP_SUBC);
      end
      OP_SHIFT: begin
        ctl.cls    = CL_SHIFT;
        ctl.writes = 1'b1;
        ctl.flags  = 1'b1;
      end
      default: ctl.cls = CL_NONE;
    endcase
  end

endmodule

// File: rtl/rfalu_regfile.sv
module rfalu_regfile #(
  parameter int DATA_W = 8,
  parameter int REG_AW = 4,
  localparam int NUM_REGS = 1 << REG_AW
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [REG_AW-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [REG_AW-1:0] xa_addr,
  output logic [DATA_W-1:0] xa_data,
  input  logic [REG_AW-1:0] ya_addr,
  output logic [DATA_W-1:0] ya_data,
  input  logic [REG_AW-1:0] obs_addr,
  output logic [DATA_W-1:0] obs_q
);

  // storage without reset so it maps onto distributed RAM
  logic [DATA_W-1:0] mem [NUM_REGS];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign xa_data = mem[xa_addr];
  assign ya_data = mem[ya_addr];

  always_ff @(posedge clk) begin
    if (rst) obs_q <= '0;
    else     obs_q <= mem[obs_addr];
  end

endmodule

// File: rtl/rfalu_arith.sv
module rfalu_arith
  import rfalu_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  class_e            cls,
  input  bitop_e            bitop,
  input  logic              with_carry,
  input  logic              cin,
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  output logic [DATA_W-1:0] res,
  output logic              cout
);

  logic [DATA_W:0]   sum;
  logic [DATA_W:0]   diff;
  logic [DATA_W:0]   cx;
  logic [DATA_W-1:0] bw;
  logic [DATA_W-1:0] conj;

  assign cx   = {{DATA_W{1'b0}}, with_carry & cin};
  assign sum  = {1'b0, a} + {1'b0, b} + cx;
  assign diff = {1'b0, a} - {1'b0, b} - cx;
  assign conj = a & b;

  always_comb begin
    case (bitop)
      BW_OR:   bw = a | b;
      BW_XOR:  bw = a ^ b;
      default: bw = conj;
    endcase
  end

  always_comb begin
    case (cls)
      CL_BITWISE: begin res = bw;               cout = 1'b0;         end
      CL_PARITY:  begin res = conj;             cout = ^conj;        end
      CL_ADDER:   begin res = sum[DATA_W-1:0];  cout = sum[DATA_W];  end
      CL_SUBTR:   begin res = diff[DATA_W-1:0]; cout = diff[DATA_W]; end
      default:    begin res = b;                cout = cin;          end
    endcase
  end

endmodule

// File: rtl/rfalu_shift.sv
module rfalu_shift
  import rfalu_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic [SHC_W-1:0]  code,
  input  logic              cin,
  input  logic [DATA_W-1:0] a,
  output logic [DATA_W-1:0] res,
  output logic              cout,
  output logic              ok
);

  localparam int MSB = DATA_W - 1;

  logic fill;
  logic left;

  always_comb begin
    ok   = 1'b1;
    left = 1'b1;
    fill = 1'b0;
    case (code)
      SH_L_CARRY: fill = cin;
      SH_L_ROT:   fill = a[MSB];
      SH_L_KEEP:  fill = a[0];
      SH_L_ZERO:  fill = 1'b0;
      SH_L_ONE:   fill = 1'b1;
      SH_R_CARRY: begin left = 1'b0; fill = cin;    end
      SH_R_KEEP:  begin left = 1'b0; fill = a[MSB]; end
      SH_R_ROT:   begin left = 1'b0; fill = a[0];   end
      SH_R_ZERO:  begin left = 1'b0; fill = 1'b0;   end
      SH_R_ONE:   begin left = 1'b0; fill = 1'b1;   end
      default:    ok = 1'b0;
    endcase
  end

  always_comb begin
    if (left) begin
      res  = {a[MSB-1:0], fill};
      cout = a[MSB];
    end else begin
      res  = {fill, a[MSB:1]};
      cout = a[0];
    end
  end

endmodule

// File: rtl/rf_alu_core.sv
module rf_alu_core
  import rfalu_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int REG_AW = 4,
  localparam int INSTR_W = OPC_W + 1 + REG_AW + DATA_W
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               en,
  input  logic               instr_valid,
  input  logic [INSTR_W-1:0] instr,
  input  logic [REG_AW-1:0]  rd_addr,
  output logic [DATA_W-1:0]  rd_data,
  output logic               flag_z,
  output logic               flag_c
);

  ctl_t              ctl;
  logic              sel_reg;
  logic [REG_AW-1:0] x_addr;
  logic [REG_AW-1:0] y_addr;
  logic [DATA_W-1:0] imm;
  logic [DATA_W-1:0] x_val;
  logic [DATA_W-1:0] y_val;
  logic [DATA_W-1:0] opnd;
  logic [DATA_W-1:0] ar_res;
  logic              ar_c;
  logic [DATA_W-1:0] sh_res;
  logic              sh_c;
  logic              sh_ok;
  logic [DATA_W-1:0] result;
  logic              res_c;
  logic              legal;
  logic              go;
  logic              wr_en;
  logic              flag_upd;
  logic [OPC_W-1:0]  op_field;

  assign op_field = instr[INSTR_W-1 -: OPC_W];

  rfalu_decode #(.DATA_W(DATA_W), .REG_AW(REG_AW)) u_dec (
    .instr   (instr),
    .ctl     (ctl),
    .sel_reg (sel_reg),
    .x_addr  (x_addr),
    .y_addr  (y_addr),
    .imm     (imm)
  );

  rfalu_regfile #(.DATA_W(DATA_W), .REG_AW(REG_AW)) u_rf (
    .clk      (clk),
    .rst      (rst),
    .we       (wr_en),
    .waddr    (x_addr),
    .wdata    (result),
    .xa_addr  (x_addr),
    .xa_data  (x_val),
    .ya_addr  (y_addr),
    .ya_data  (y_val),
    .obs_addr (rd_addr),
    .obs_q    (rd_data)
  );

  assign opnd = sel_reg ? y_val : imm;

  rfalu_arith #(.DATA_W(DATA_W)) u_arith (
    .cls        (ctl.cls),
    .bitop      (ctl.bitop),
    .with_carry (ctl.with_carry),
    .cin        (flag_c),
    .a          (x_val),
    .b          (opnd),
    .res        (ar_res),
    .cout       (ar_c)
  );

  rfalu_shift #(.DATA_W(DATA_W)) u_shift (
    .code (imm[SHC_W-1:0]),
    .cin  (flag_c),
    .a    (x_val),
    .res  (sh_res),
    .cout (sh_c),
    .ok   (sh_ok)
  );

  assign result   = (ctl.cls == CL_SHIFT) ? sh_res : ar_res;
  assign res_c    = (ctl.cls == CL_SHIFT) ? sh_c   : ar_c;
  assign legal    = (ctl.cls != CL_NONE) && ((ctl.cls != CL_SHIFT) || sh_ok);
  assign go       = en && instr_valid;
  assign wr_en    = go && legal && ctl.writes;
  assign flag_upd = go && legal && ctl.flags;

  always_ff @(posedge clk) begin
    if (rst) begin
      flag_z <= 1'b0;
      flag_c <= 1'b0;
    end else if (flag_upd) begin
      flag_z <= (result == '0);
      flag_c <= res_c;
    end
  end

endmodule

// File: rtl/rfalu_checker.sv
module rfalu_checker
  import rfalu_pkg::*;
(
  input logic             clk,
  input logic             rst,
  input logic             en,
  input logic             instr_valid,
  input logic [OPC_W-1:0] op_field,
  input logic             wr_en,
  input logic             flag_z,
  input logic             flag_c
);

  logic go;
  assign go = en && instr_valid;

  AST_WR_NEEDS_STROBE: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> go) else $error("write without enable and valid"); // R10

  AST_FLAGS_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
    !go |=> ($stable(flag_z) && $stable(flag_c))) else $error("flags moved while idle"); // R10

  AST_COPY_KEEPS_FLAGS: assert property (@(posedge clk) disable iff (rst)
    (go && op_field == OP_LOAD) |=> ($stable(flag_z) && $stable(flag_c))) else $error("copy changed flags"); // R2

  AST_BITWISE_CLEARS_C: assert property (@(posedge clk) disable iff (rst)
    (go && (op_field == OP_AND || op_field == OP_OR || op_field == OP_XOR)) |=> !flag_c) else $error("bitwise left C set"); // R3

  AST_TEST_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
    (op_field == OP_TEST) |-> !wr_en) else $error("test wrote a register"); // R6

  AST_CMP_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
    (op_field == OP_CMP) |-> !wr_en) else $error("compare wrote a register"); // R7

  AST_UNDEF_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
    !(op_field inside {OP_LOAD, OP_AND, OP_OR, OP_XOR, OP_TEST, OP_CMP, OP_ADD,
                       OP_ADDC, OP_SUB, OP_SUBC, OP_SHIFT}) |-> !wr_en) else $error("undefined opcode wrote"); // R9

  AST_UNDEF_KEEPS_FLAGS: assert property (@(posedge clk) disable iff (rst)
    !(op_field inside {OP_AND, OP_OR, OP_XOR, OP_TEST, OP_CMP, OP_ADD,
                       OP_ADDC, OP_SUB, OP_SUBC, OP_SHIFT}) |=> ($stable(flag_z) && $stable(flag_c))) else $error("flags moved on non-flag opcode"); // R9

endmodule

bind rf_alu_core rfalu_checker u_chk (
  .clk         (clk),
  .rst         (rst),
  .en          (en),
  .instr_valid (instr_valid),
  .op_field    (op_field),
  .wr_en       (wr_en),
  .flag_z      (flag_z),
  .flag_c      (flag_c)
);

// File: tb/sim_rf_alu_core.sv
module sim_rf_alu_core;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG_CYCLES = 190000;

  localparam logic [4:0] C_LOAD  = 5'b00000;
  localparam logic [4:0] C_AND   = 5'b00101;
  localparam logic [4:0] C_OR    = 5'b00110;
  localparam logic [4:0] C_XOR   = 5'b00111;
  localparam logic [4:0] C_TEST  = 5'b01001;
  localparam logic [4:0] C_CMP   = 5'b01010;
  localparam logic [4:0] C_ADD   = 5'b01100;
  localparam logic [4:0] C_ADDC  = 5'b01101;
  localparam logic [4:0] C_SUB   = 5'b01110;
  localparam logic [4:0] C_SUBC  = 5'b01111;
  localparam logic [4:0] C_SHIFT = 5'b10000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        en = 1'b0;
  logic        instr_valid = 1'b0;
  logic [17:0] instr = '0;
  logic [3:0]  rd_addr = 4'd3;
  logic [7:0]  rd_data;
  logic        flag_z;
  logic        flag_c;

  int n_tests = 0;
  int n_fail  = 0;

  rf_alu_core u0 (
    .clk         (clk),
    .rst         (rst),
    .en          (en),
    .instr_valid (instr_valid),
    .instr       (instr),
    .rd_addr     (rd_addr),
    .rd_data     (rd_data),
    .flag_z      (flag_z),
    .flag_c      (flag_c)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [17:0] enc(input logic [4:0] op, input logic regsel,
                                      input logic [3:0] x, input logic [7:0] low);
    return {op, regsel, x, low};
  endfunction

  task automatic drive(input logic [17:0] w, input logic v, input logic e);
    @(negedge clk);
    instr = w; instr_valid = v; en = e;
    @(negedge clk);
    instr_valid = 1'b0; instr = '0;
  endtask

  task automatic issue(input logic [17:0] w);
    drive(w, 1'b1, 1'b1);
  endtask

  // leaves C = c, Z = 1, register 15 = 0
  task automatic set_carry(input logic c);
    issue(enc(C_LOAD, 1'b0, 4'd15, {7'd0, c}));
    issue(enc(C_SHIFT, 1'b0, 4'd15, 8'h0E));
  endtask

  task automatic read_reg(input logic [3:0] addr, output logic [7:0] val);
    @(negedge clk);
    rd_addr = addr;
    @(negedge clk);
    val = rd_data;
  endtask

  function automatic string tag_of(input logic [4:0] op);
    case (op)
      C_AND, C_OR, C_XOR: return "R3";
      C_ADD, C_ADDC:      return "R4";
      C_SUB, C_SUBC:      return "R5";
      C_TEST:             return "R6";
      C_CMP:              return "R7";
      default:            return "R8";
    endcase
  endfunction

  // expected register value, Z and C computed from the requirements
  task automatic model(input logic [4:0] op, input logic [7:0] a, input logic [7:0] b,
                       input logic cin, output logic [7:0] r, output logic z, output logic c);
    int s;
    logic [7:0] t;
    r = a; c = 1'b0; t = 8'h00;
    case (op)
      C_AND: begin r = a & b; t = r; end
      C_OR:  begin r = a | b; t = r; end
      C_XOR: begin r = a ^ b; t = r; end
      C_TEST: begin t = a & b; c = ^t; end
      C_ADD, C_ADDC: begin
        s = int'(a) + int'(b) + ((op == C_ADDC) ? int'(cin) : 0);
        r = s[7:0]; t = r; c = (s > 255);
      end
      C_SUB, C_SUBC, C_CMP: begin
        s = int'(a) - int'(b) - ((op == C_SUBC) ? int'(cin) : 0);
        t = s[7:0]; c = (s < 0);
        if (op != C_CMP) r = t;
      end
      default: ;
    endcase
    z = (t == 8'h00);
  endtask

  task automatic shift_model(input logic [3:0] code, input logic [7:0] a, input logic cin,
                             output logic [7:0] r, output logic c);
    logic f;
    f = 1'b0;
    if (!code[3]) begin
      case (code)
        4'b0000: f = cin;
        4'b0010: f = a[7];
        4'b0100: f = a[0];
        4'b0111: f = 1'b1;
        default: f = 1'b0;
      endcase
      r = ((a << 1) & 8'hFE) | {7'd0, f};
      c = a[7];
    end else begin
      case (code)
        4'b1000: f = cin;
        4'b1010: f = a[7];
        4'b1100: f = a[0];
        4'b1111: f = 1'b1;
        default: f = 1'b0;
      endcase
      r = (a >> 1) | {f, 7'd0};
      c = a[0];
    end
  endtask

  initial begin : watchdog
    repeat (WATCHDOG_CYCLES) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: actual running expected finished");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin : stim
    logic [7:0] v, er;
    logic ez, ec;
    logic [7:0] blist [8];
    logic [4:0] ops [9];
    logic [3:0] scodes [10];
    blist  = '{8'h00, 8'h01, 8'h0F, 8'h55, 8'h7F, 8'h80, 8'hAA, 8'hFF};
    ops    = '{C_AND, C_OR, C_XOR, C_TEST, C_CMP, C_ADD, C_ADDC, C_SUB, C_SUBC};
    scodes = '{4'b0000, 4'b0010, 4'b0100, 4'b0110, 4'b0111,
               4'b1000, 4'b1010, 4'b1100, 4'b1110, 4'b1111};

    // R11 reset state
    repeat (3) @(negedge clk);
    check("R11", "Z in reset", flag_z, 1'b0);
    check("R11", "C in reset", flag_c, 1'b0);
    check("R11", "read port in reset", rd_data, 8'h00);
    rst = 1'b0;

    // R12 load every register, read each back
    for (int i = 0; i < 16; i++)
      issue(enc(C_LOAD, 1'b0, 4'(i), 8'(i * 17) ^ 8'h5A));
    for (int i = 0; i < 16; i++) begin
      read_reg(4'(i), v);
      check("R12", "register readback", v, 8'(i * 17) ^ 8'h5A);
    end
    rd_addr = 4'd3;

    // R2 copy keeps flags, both operand forms
    set_carry(1'b1);
    issue(enc(C_LOAD, 1'b0, 4'd3, 8'h00));
    check("R2", "Z after copy", flag_z, 1'b1);
    check("R2", "C after copy", flag_c, 1'b1);
    issue(enc(C_LOAD, 1'b0, 4'd2, 8'hC3));
    issue(enc(C_LOAD, 1'b1, 4'd3, {4'd2, 4'd0}));
    read_reg(4'd3, v);
    check("R2", "copy from register", v, 8'hC3);
    check("R2", "C after register copy", flag_c, 1'b1);

    // R1 destination equals sY
    issue(enc(C_LOAD, 1'b0, 4'd7, 8'h40));
    issue(enc(C_ADD, 1'b1, 4'd7, {4'd7, 4'd0}));
    read_reg(4'd7, v);
    check("R1", "sX==sY add", v, 8'h80);
    check("R1", "sX==sY carry", flag_c, 1'b0);
    rd_addr = 4'd3;

    // R3..R7 sweep, operand form alternates so bit 12 matters (R1)
    for (int ia = 0; ia < 256; ia += 3) begin
      for (int jb = 0; jb < 8; jb++) begin
        for (int k = 0; k < 9; k++) begin
          logic cin, rmode;
          cin   = 1'(ia ^ jb ^ k);
          rmode = 1'((ia >> 1) ^ jb);
          set_carry(cin);
          issue(enc(C_LOAD, 1'b0, 4'd3, 8'(ia)));
          issue(enc(C_LOAD, 1'b0, 4'd2, blist[jb]));
          if (rmode) issue(enc(ops[k], 1'b1, 4'd3, {4'd2, 4'd0}));
          else       issue(enc(ops[k], 1'b0, 4'd3, blist[jb]));
          model(ops[k], 8'(ia), blist[jb], cin, er, ez, ec);
          check(tag_of(ops[k]), "Z flag", flag_z, ez);
          check(tag_of(ops[k]), "C flag", flag_c, ec);
          @(negedge clk);
          check(tag_of(ops[k]), "sX value", rd_data, er);
        end
      end
    end

    // R8 all ten shift codes, every value, both carry inputs
    for (int ia = 0; ia < 256; ia++) begin
      for (int k = 0; k < 10; k++) begin
        logic cin;
        cin = 1'(ia ^ k);
        set_carry(cin);
        issue(enc(C_LOAD, 1'b0, 4'd3, 8'(ia)));
        issue(enc(C_SHIFT, 1'b0, 4'd3, {4'd0, scodes[k]}));
        shift_model(scodes[k], 8'(ia), cin, er, ec);
        check("R8", "shift C", flag_c, ec);
        check("R8", "shift Z", flag_z, er == 8'h00);
        @(negedge clk);
        check("R8", "shift result", rd_data, er);
      end
    end

    // R9 undefined opcode and undefined shift code
    set_carry(1'b1);
    issue(enc(C_LOAD, 1'b0, 4'd3, 8'h96));
    issue(enc(5'b00001, 1'b0, 4'd3, 8'h11));
    issue(enc(5'b11000, 1'b0, 4'd3, 8'h00));
    issue(enc(C_SHIFT, 1'b0, 4'd3, 8'h01));
    issue(enc(C_SHIFT, 1'b0, 4'd3, 8'h0B));
    check("R9", "Z unchanged", flag_z, 1'b1);
    check("R9", "C unchanged", flag_c, 1'b1);
    @(negedge clk);
    check("R9", "sX unchanged", rd_data, 8'h96);

    // R10 enable low, then valid low
    set_carry(1'b1);
    issue(enc(C_LOAD, 1'b0, 4'd3, 8'h3C));
    drive(enc(C_ADD, 1'b0, 4'd3, 8'hC4), 1'b1, 1'b0);
    check("R10", "Z with en low", flag_z, 1'b1);
    check("R10", "C with en low", flag_c, 1'b1);
    drive(enc(C_XOR, 1'b0, 4'd3, 8'h3C), 1'b0, 1'b1);
    check("R10", "C with valid low", flag_c, 1'b1);
    @(negedge clk);
    check("R10", "sX unchanged", rd_data, 8'h3C);

    // R11 registers survive reset, flags cleared
    issue(enc(C_LOAD, 1'b0, 4'd5, 8'hA5));
    set_carry(1'b1);
    @(negedge clk);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    check("R11", "C after reset", flag_c, 1'b0);
    check("R11", "Z after reset", flag_z, 1'b0);
    rst = 1'b0;
    read_reg(4'd5, v);
    check("R11", "register kept over reset", v, 8'hA5);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule